// File: doc/BRIEF.md
# Successive-Approximation Tuned Digital Phase Tracker

This block locks a numerically controlled oscillator to a slow beat signal that has already been cleaned by upstream filtering. It delivers the oscillator phase as a running phase estimate. Reference samples arrive as a signed stream with a valid strobe. A start pulse arms a holdoff timer, which hides the filter settling transient from the loop. The loop first finds the oscillator frequency with a binary search over a small range of phase increments, taking one decision per reference period. After the search, it trims the increment by one unit per reference period.

The oscillator is resynchronised on every rising edge of the reference. Its wrap count over one reference period tells whether it runs fast or slow. A fixed number of samples after the holdoff ends, the phase is latched as the result and a done flag goes high. The oscillator keeps running after that, so the live phase output stays valid on every sample step.

Top module: `adpll_phase_est`

## Requirements
- R1: During and after reset, before any start pulse, phase_o, result_o and done_o are all zero.
- R2: A start pulse takes priority over a sample in the same cycle. In the next cycle phase_o, result_o and done_o are zero and the holdoff restarts. The next HOLD_SAMPLES accepted samples are ignored, and phase_o stays zero through them.
- R3: A sample is accepted only in a cycle where ref_valid and en are both high. In any other cycle without a start pulse, no output and no internal state changes.
- R4: A reference rising edge is an accepted sample that is zero or positive, where the previous accepted sample since the holdoff ended was negative (sign bit set). On an edge sample, phase_o becomes 0.
- R5: On an accepted non-edge sample after the holdoff, phase_o advances by the current increment modulo 2^PHASE_W. When the sum reaches or exceeds 2^PHASE_W, it marks one oscillator wrap for the current reference period.
- R6: After start the increment is 2^(SEARCH_BITS-1). The first edge only resynchronises and leaves the increment unchanged.
- R7: Each of the next SEARCH_BITS-1 edges applies a step that starts at 2^(SEARCH_BITS-2) and halves each time, ending with the step of 1. If at least one wrap occurred since the previous edge, the step is subtracted (oscillator too fast). If none occurred, it is added.
- R8: On every later edge the increment moves by one LSB: down when a wrap occurred, up when none did. It is held within 1 to 2^SEARCH_BITS-1.
- R9: On the LOCK_SAMPLES-th accepted sample after the holdoff, result_o takes the phase_o value present before that sample and done_o rises in the next cycle. Both then hold until the next start pulse.
- R10: With a steady reference period of P samples, after the search the increment is within 2 of 2^PHASE_W/(P-1). Two consecutive non-edge samples show this as the difference in phase_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Sample acceptance enable |
| start | input | 1 | Starts a new measurement |
| ref_valid | input | 1 | Reference sample strobe |
| ref_sample | input | SAMPLE_W | Signed two's-complement reference sample |
| phase_o | output | PHASE_W | Live oscillator phase |
| result_o | output | PHASE_W | Captured phase estimate |
| done_o | output | 1 | Result captured, held until next start |

## Verification
Square-like references of several periods are used: a long period near the bottom of the increment range, a mid period, and a short period near its top. Each tests whether the binary search picks the right add or subtract decision at every bit, and whether the range limits apply. Random gaps in the valid strobe, and valid samples taken with en low, separate sample-step advance from clock advance. Occasional zero-valued samples at the crossing check which side of the edge rule counts zero. Restarting while a previous run is done checks that clearing and holdoff masking take priority over a live reference.

// File: rtl/adpll_pkg.sv
package adpll_pkg;
   typedef enum logic [1:0] {TUNE_SYNC, TUNE_SAR, TUNE_FINE} tune_mode_t;
   typedef enum logic [1:0] {TMR_IDLE, TMR_HOLD, TMR_RUN} tmr_state_t;
endpackage

// File: rtl/adpll_timer.sv
module adpll_timer
   import adpll_pkg::*;
#(
   parameter int HOLD_SAMPLES = 3000,
   parameter int LOCK_SAMPLES = 24000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic accept,
   output logic run,
   output logic capture,
   output logic done
);
   localparam int HW = (HOLD_SAMPLES > 1) ? $clog2(HOLD_SAMPLES) : 1;
   localparam int LW = (LOCK_SAMPLES > 1) ? $clog2(LOCK_SAMPLES) : 1;

   tmr_state_t    state;
   logic [HW-1:0] hold_cnt;
   logic [LW-1:0] lock_cnt;

   assign run     = (state == TMR_RUN);
   assign capture = run && accept && !start && !done && (lock_cnt == LW'(LOCK_SAMPLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= TMR_IDLE;
         hold_cnt <= '0;
         lock_cnt <= '0;
         done     <= 1'b0;
      end else if (start) begin
         state    <= TMR_HOLD;
         hold_cnt <= '0;
         lock_cnt <= '0;
         done     <= 1'b0;
      end else if (accept) begin
         case (state)
            TMR_HOLD: begin
               if (hold_cnt == HW'(HOLD_SAMPLES - 1)) state <= TMR_RUN;
               else hold_cnt <= hold_cnt + 1'b1;
            end
            TMR_RUN: begin
               if (capture) done <= 1'b1;
               else if (!done) lock_cnt <= lock_cnt + 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/adpll_edge.sv
module adpll_edge #(
   parameter int SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                step_run,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                edge_o
);
   logic prev_neg;
   logic prev_ok;

   assign edge_o = step_run && prev_ok && prev_neg && !sample[SAMPLE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_neg <= 1'b0;
         prev_ok  <= 1'b0;
      end else if (clear) begin
         prev_neg <= 1'b0;
         prev_ok  <= 1'b0;
      end else if (step_run) begin
         prev_neg <= sample[SAMPLE_W-1];
         prev_ok  <= 1'b1;
      end
   end
endmodule

// File: rtl/adpll_dco.sv
module adpll_dco #(
   parameter int PHASE_W = 20,
   parameter int WRAP_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               step_run,
   input  logic               sync,
   input  logic [PHASE_W-1:0] inc,
   output logic [PHASE_W-1:0] phase,
   output logic               wrapped
);
   logic [PHASE_W:0] sum;
   assign sum = {1'b0, phase} + {1'b0, inc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 phase <= '0;
      else if (clear)             phase <= '0;
      else if (step_run && sync)  phase <= '0;
      else if (step_run)          phase <= sum[PHASE_W-1:0];
   end

   generate
      if (WRAP_W == 1) begin : g_flag
         logic seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                seen <= 1'b0;
            else if (clear)            seen <= 1'b0;
            else if (step_run && sync) seen <= 1'b0;
            else if (step_run && sum[PHASE_W]) seen <= 1'b1;
         end
         assign wrapped = seen;
      end else begin : g_count
         logic [WRAP_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (clear)            cnt <= '0;
            else if (step_run && sync) cnt <= '0;
            else if (step_run && sum[PHASE_W] && (cnt != '1)) cnt <= cnt + 1'b1;
         end
         assign wrapped = (cnt != '0);
      end
   endgenerate
endmodule

// File: rtl/adpll_tune.sv
module adpll_tune
   import adpll_pkg::*;
#(
   parameter int PHASE_W     = 20,
   parameter int SEARCH_BITS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               sync,
   input  logic               fast,
   output logic [PHASE_W-1:0] inc
);
   localparam logic [PHASE_W-1:0] INC_INIT  = PHASE_W'(1) << (SEARCH_BITS - 1);
   localparam logic [PHASE_W-1:0] INC_MAX   = (PHASE_W'(1) << SEARCH_BITS) - PHASE_W'(1);
   localparam logic [PHASE_W-1:0] STEP_INIT = INC_INIT >> 1;

   tune_mode_t         mode;
   logic [PHASE_W-1:0] step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clear) begin
         mode <= TUNE_SYNC;
         inc  <= INC_INIT;
         step <= STEP_INIT;
      end else if (sync) begin
         case (mode)
            TUNE_SYNC: mode <= TUNE_SAR;
            TUNE_SAR: begin
               inc  <= fast ? (inc - step) : (inc + step);
               step <= step >> 1;
               if (step == PHASE_W'(1)) mode <= TUNE_FINE;
            end
            default: begin
               if (fast) inc <= (inc == PHASE_W'(1)) ? inc : inc - PHASE_W'(1);
               else      inc <= (inc == INC_MAX)     ? inc : inc + PHASE_W'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/adpll_phase_est.sv
module adpll_phase_est #(
   parameter int SAMPLE_W     = 12,
   parameter int PHASE_W      = 20,
   parameter int SEARCH_BITS  = 12,
   parameter int WRAP_W       = 2,
   parameter int HOLD_SAMPLES = 3000,
   parameter int LOCK_SAMPLES = 24000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                start,
   input  logic                ref_valid,
   input  logic [SAMPLE_W-1:0] ref_sample,
   output logic [PHASE_W-1:0]  phase_o,
   output logic [PHASE_W-1:0]  result_o,
   output logic                done_o
);
   generate
      if (SEARCH_BITS < 2 || SEARCH_BITS > PHASE_W) begin : g_bad_search
         $error("SEARCH_BITS must lie in 2..PHASE_W");
      end
      if (HOLD_SAMPLES < 1 || LOCK_SAMPLES < 1) begin : g_bad_time
         $error("HOLD_SAMPLES and LOCK_SAMPLES must be positive");
      end
      if (SAMPLE_W < 2 || WRAP_W < 1) begin : g_bad_width
         $error("SAMPLE_W must be at least 2 and WRAP_W at least 1");
      end
   endgenerate

   logic               accept;
   logic               run_active;
   logic               capture;
   logic               step_run;
   logic               ref_edge;
   logic               osc_fast;
   logic [PHASE_W-1:0] tune_inc;

   assign accept   = ref_valid && en;
   assign step_run = accept && run_active && !start;

   adpll_timer #(.HOLD_SAMPLES(HOLD_SAMPLES), .LOCK_SAMPLES(LOCK_SAMPLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
      .run(run_active), .capture(capture), .done(done_o));

   adpll_edge #(.SAMPLE_W(SAMPLE_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .clear(start), .step_run(step_run),
      .sample(ref_sample), .edge_o(ref_edge));

   adpll_dco #(.PHASE_W(PHASE_W), .WRAP_W(WRAP_W)) u_dco (
      .clk(clk), .rst_n(rst_n), .clear(start), .step_run(step_run),
      .sync(ref_edge), .inc(tune_inc), .phase(phase_o), .wrapped(osc_fast));

   adpll_tune #(.PHASE_W(PHASE_W), .SEARCH_BITS(SEARCH_BITS)) u_tune (
      .clk(clk), .rst_n(rst_n), .clear(start), .sync(ref_edge),
      .fast(osc_fast), .inc(tune_inc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       result_o <= '0;
      else if (start)   result_o <= '0;
      else if (capture) result_o <= phase_o;
   end
endmodule

// File: rtl/adpll_phase_est_chk.sv
module adpll_phase_est_chk #(
   parameter int PHASE_W     = 20,
   parameter int SEARCH_BITS = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic               start,
   input logic               ref_valid,
   input logic               ref_edge,
   input logic [PHASE_W-1:0] phase_o,
   input logic [PHASE_W-1:0] result_o,
   input logic               done_o,
   input logic [PHASE_W-1:0] tune_inc
);
   localparam logic [PHASE_W-1:0] INC_TOP = (PHASE_W'(1) << SEARCH_BITS) - PHASE_W'(1);

   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done_o && phase_o == '0 && result_o == '0)); // R2

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !(ref_valid && en)) |=> ($stable(phase_o) && $stable(result_o) && $stable(done_o))); // R3

   AST_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ref_edge |=> (phase_o == '0)); // R4

   AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (tune_inc >= PHASE_W'(1) && tune_inc <= INC_TOP)); // R8

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start) |=> (done_o && $stable(result_o))); // R9
endmodule

bind adpll_phase_est adpll_phase_est_chk #(.PHASE_W(PHASE_W), .SEARCH_BITS(SEARCH_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .start(start), .ref_valid(ref_valid),
   .ref_edge(ref_edge), .phase_o(phase_o), .result_o(result_o), .done_o(done_o),
   .tune_inc(tune_inc));

// File: tb/sim_adpll_phase_est.sv
module sim_adpll_phase_est;
   localparam int SW   = 12;
   localparam int PW   = 20;
   localparam int SB   = 12;
   localparam int HOLD = 37;
   localparam int LOCK = 12000;
   localparam longint MODV = 64'd1 << PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          start = 1'b0;
   logic          ref_valid = 1'b0;
   logic [SW-1:0] ref_sample = '0;
   logic [PW-1:0] phase_o;
   logic [PW-1:0] result_o;
   logic          done_o;

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   // bench model state
   int     m_state = 0;
   int     m_hold = 0, m_lock = 0, m_mode = 0;
   bit     m_done = 0, m_pok = 0, m_prev_neg = 0, m_wrap = 0;
   longint m_phase = 0, m_res = 0, m_inc = 0, m_step = 0;

   always #4 clk = ~clk;

   adpll_phase_est #(.SAMPLE_W(SW), .PHASE_W(PW), .SEARCH_BITS(SB),
                     .HOLD_SAMPLES(HOLD), .LOCK_SAMPLES(LOCK)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .start(start), .ref_valid(ref_valid),
      .ref_sample(ref_sample), .phase_o(phase_o), .result_o(result_o), .done_o(done_o));

   function automatic longint inc_init();
      return 64'd1 << (SB - 1);
   endfunction

   function automatic longint expect_inc(input int p);
      return MODV / longint'(p - 1);
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   endtask

   task automatic compare();
      checks++;
      if (phase_o !== PW'(m_phase) || result_o !== PW'(m_res) || done_o !== m_done) begin
         bad++;
         $display("FAIL R2/R3/R4/R5/R6/R7/R8/R9 phase=%0d/%0d result=%0d/%0d done=%0b/%0b (actual/expected)",
                  phase_o, m_phase, result_o, m_res, done_o, m_done);
      end
   endtask

   // expected behaviour per accepted sample, written from the requirements
   task automatic model(input bit v, input bit e, input bit s, input logic [SW-1:0] x);
      bit edge_now;
      longint sum;
      if (s) begin // R2
         m_state = 1; m_hold = 0; m_lock = 0; m_done = 0; m_res = 0; m_phase = 0;
         m_wrap = 0; m_inc = inc_init(); m_step = inc_init() >> 1; m_mode = 0; m_pok = 0; m_prev_neg = 0;
      end else if (v && e) begin // R3
         if (m_state == 1) begin
            if (m_hold == HOLD - 1) m_state = 2; else m_hold++;
         end else if (m_state == 2) begin
            if (!m_done) begin // R9
               if (m_lock == LOCK - 1) begin m_done = 1; m_res = m_phase; end
               else m_lock++;
            end
            edge_now = m_pok && m_prev_neg && !x[SW-1]; // R4
            m_prev_neg = x[SW-1];
            m_pok = 1;
            if (edge_now) begin
               if (m_mode == 0) m_mode = 1; // R6
               else if (m_mode == 1) begin // R7
                  m_inc = m_wrap ? m_inc - m_step : m_inc + m_step;
                  if (m_step == 1) m_mode = 2;
                  m_step = m_step >> 1;
               end else begin // R8
                  if (m_wrap) m_inc = (m_inc == 1) ? 1 : m_inc - 1;
                  else m_inc = (m_inc == (64'd1 << SB) - 1) ? m_inc : m_inc + 1;
               end
               m_phase = 0; m_wrap = 0;
            end else begin // R5
               sum = m_phase + m_inc;
               if (sum >= MODV) m_wrap = 1;
               m_phase = sum % MODV;
            end
         end
      end
   endtask

   task automatic cyc(input bit v, input bit e, input bit s, input logic [SW-1:0] x);
      @(negedge clk);
      compare();
      ref_valid = v; en = e; start = s; ref_sample = x;
      model(v, e, s, x);
   endtask

   task automatic run_seq(input int p, input int nsamp);
      int idx = 0;
      int cnt = 0;
      int r;
      logic [PW-1:0] p1, p2;
      longint diff, want;
      cyc(1'b1, 1'b1, 1'b1, SW'(-300)); // start wins over the sample, R2
      while (cnt < nsamp) begin
         r = int'($urandom % 16);
         if (r == 0) cyc(1'b0, 1'b1, 1'b0, SW'($urandom));      // R3 gap
         else if (r == 1) cyc(1'b1, 1'b0, 1'b0, SW'($urandom)); // R3 en low
         else begin
            logic [SW-1:0] x;
            if ((idx % p) < p / 2) x = SW'(-(100 + int'($urandom % 1000)));
            else if ((idx % p) == p / 2 && r < 5) x = '0; // zero counts as rising, R4
            else x = SW'(100 + int'($urandom % 1000));
            cyc(1'b1, 1'b1, 1'b0, x);
            idx++; cnt++;
         end
      end
      // R10: measure increment from two clean non-edge steps
      cyc(1'b1, 1'b1, 1'b0, SW'(500));
      cyc(1'b1, 1'b1, 1'b0, SW'(500));
      cyc(1'b0, 1'b1, 1'b0, '0);
      p1 = phase_o;
      cyc(1'b1, 1'b1, 1'b0, SW'(500));
      cyc(1'b0, 1'b1, 1'b0, '0);
      p2 = phase_o;
      diff = (longint'(p2) - longint'(p1) + MODV) % MODV;
      want = expect_inc(p);
      checks++;
      if (diff > want + 2 || diff + 2 < want) begin
         bad++;
         $display("FAIL R10 period=%0d inc=%0d expected=%0d", p, diff, want);
      end
      checks++;
      if (done_o !== 1'b1) begin
         bad++;
         $display("FAIL R9 done=%0b expected=1", done_o);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd1357));
      m_inc = inc_init(); m_step = inc_init() >> 1;
      repeat (3) @(negedge clk);
      checks++; // R1
      if (phase_o !== '0 || result_o !== '0 || done_o !== 1'b0) begin
         bad++;
         $display("FAIL R1 phase=%0d result=%0d done=%0b expected 0/0/0", phase_o, result_o, done_o);
      end
      rst_n = 1'b1;
      cyc(1'b1, 1'b1, 1'b0, SW'(400)); // no start yet: R1 outputs stay zero
      cyc(1'b1, 1'b1, 1'b0, SW'(-400));
      cyc(1'b1, 1'b1, 1'b0, SW'(400));
      run_seq(1000, 16000);
      run_seq(437, 12600);
      run_seq(2000, 30000);
      run_seq(260, 12600);  // near top of search range, R8
      cyc(1'b0, 1'b1, 1'b0, '0);
      summary();
   end
endmodule